// File: doc/BRIEF.md
# Multi-Mode Operand Address Generator

This block produces the source operand of a two-operand instruction. Decode hands it a mode code, the base and index register values, an address constant, an immediate and an operand size. The block then does one of three things:

- returns a register value or the immediate directly, or
- forms an effective address and fetches the operand over a simple memory read port, or
- makes two chained reads when the operand sits behind a pointer held in memory.

Two modes also step the base register by the operand size. For those modes the block hands the new base value back with a write-back enable, so the register file can update it.

Requests enter on a valid/ready handshake. `req_ready` is high only while the block is idle. A request is taken on a rising edge where `req_valid` and `req_ready` are both high, and every request field is sampled on that edge.

Results leave on a second valid/ready handshake. Once `res_valid` rises, the result, the illegal flag, the write-back enable and the write-back value all stay fixed until the consumer raises `res_ready`. While the consumer holds `res_ready` low, no new request is taken. The read port has no back-pressure: read data is returned in the cycle after `mem_rd_en`.

Top module: `operand_addr_gen`

## Requirements
- R1: After reset, `req_ready` is 1 while `res_valid` and `mem_rd_en` are 0. `req_ready` is 0 from the accepting edge until the result handshake completes.
- R2: Mode 0 returns `req_base` and mode 1 returns `req_imm`. Neither issues a memory read, and `res_valid` is high in the cycle straight after acceptance.
- R3: A single read is made at one of these addresses:
  - mode 2: constant + base
  - mode 3: base
  - mode 4: base + index
  - mode 5: constant
  
  The read data is the result. `res_valid` rises on the third rising edge counted from the accepting edge.
- R4: Mode 6 first reads at base. The returned word is used as the address of a second read, whose data is the result. `res_valid` rises on the fourth edge counted from the accepting edge.
- R5: Mode 7 reads at base and returns base + d as the write-back value.
- R6: Mode 8 reads at base − d and returns base − d as the write-back value.
- R7: Mode 9 reads at constant + base + (index << size code).
- R8: Size code 0, 1, 2 and 3 gives d = 1, 2, 4 and 8 bytes. All address arithmetic wraps modulo 2^WORD_W.
- R9: Codes 10 to 15 finish after one cycle with `res_illegal` = 1 and result 0. They make no read and no write-back.
- R10: `wb_en` is high only for modes 7 and 8, and only while `res_valid` is high.
- R11: While `res_valid` is high and `res_ready` is low, `res_valid` stays high. `res_data`, `res_illegal`, `wb_en` and `wb_data` hold their values.
- R12: Each read is one cycle of `mem_rd_en` with `mem_addr`. `mem_rdata` is taken in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Block idle, request accepted this edge if valid |
| req_mode | input | 4 | Addressing mode code |
| req_size | input | 2 | Operand size code (d = 1 << code) |
| req_base | input | WORD_W | Base register value |
| req_index | input | WORD_W | Index register value |
| req_const | input | WORD_W | Displacement or absolute address |
| req_imm | input | WORD_W | Immediate operand |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | WORD_W | Memory read address |
| mem_rdata | input | WORD_W | Read data, valid the cycle after the strobe |
| res_valid | output | 1 | Operand result valid (done) |
| res_ready | input | 1 | Consumer accepts the result |
| res_data | output | WORD_W | Operand value |
| res_illegal | output | 1 | Mode code was not legal |
| wb_en | output | 1 | Base register write-back enable |
| wb_data | output | WORD_W | New base register value |

## Verification
The bench builds the block with WORD_W = 16. With that width, wrap-around is cheap to reach:
- post-increment of 0xFFFF by 8 wraps to 0x0007;
- pre-decrement of 0x0000 by 1 wraps to 0xFFFF;
- scaled indexing can be checked at all four shift amounts.

The bench models memory as a computed function of the address. This gives each pointer-chasing read a distinct, predictable second address. A phase with the consumer stalling exercises result hold and request blocking.

// File: rtl/oag_pkg.sv
package oag_pkg;

  localparam int unsigned MODE_W = 4;
  localparam int unsigned SIZE_W = 2;

  typedef enum logic [MODE_W-1:0] {
    AM_REG     = 4'd0,
    AM_IMM     = 4'd1,
    AM_DISP    = 4'd2,
    AM_RIND    = 4'd3,
    AM_INDEX   = 4'd4,
    AM_ABS     = 4'd5,
    AM_MIND    = 4'd6,
    AM_POSTINC = 4'd7,
    AM_PREDEC  = 4'd8,
    AM_SCALED  = 4'd9
  } amode_e;

  typedef enum logic [2:0] {
    S_IDLE,
    S_RD1,
    S_CAP1,
    S_CAP2,
    S_DONE
  } seq_e;

  function automatic logic mode_legal(input logic [MODE_W-1:0] m);
    return m <= AM_SCALED;
  endfunction

  function automatic logic mode_has_wb(input logic [MODE_W-1:0] m);
    return (m == AM_POSTINC) || (m == AM_PREDEC);
  endfunction

  function automatic logic mode_no_mem(input logic [MODE_W-1:0] m);
    return (m == AM_REG) || (m == AM_IMM);
  endfunction

endpackage

// File: rtl/oag_ea_unit.sv
module oag_ea_unit
  import oag_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic [MODE_W-1:0] mode_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] index_i,
  input  logic [WORD_W-1:0] konst_i,
  output logic [WORD_W-1:0] ea_o,
  output logic [WORD_W-1:0] wb_val_o
);

  logic [WORD_W-1:0] step;
  logic [WORD_W-1:0] scaled_idx;
  logic [WORD_W-1:0] base_inc;
  logic [WORD_W-1:0] base_dec;

  // operand size in bytes and index scaling are both a shift by the size code
  always_comb begin
    step       = WORD_W'(1) << size_i;
    scaled_idx = index_i << size_i;
    base_inc   = base_i + step;
    base_dec   = base_i - step;
  end

  always_comb begin
    unique case (mode_i)
      AM_DISP:    ea_o = konst_i + base_i;
      AM_RIND,
      AM_MIND,
      AM_POSTINC: ea_o = base_i;
      AM_INDEX:   ea_o = base_i + index_i;
      AM_ABS:     ea_o = konst_i;
      AM_PREDEC:  ea_o = base_dec;
      AM_SCALED:  ea_o = konst_i + base_i + scaled_idx;
      default:    ea_o = '0;
    endcase
    wb_val_o = (mode_i == AM_PREDEC) ? base_dec : base_inc;
  end

endmodule

// File: rtl/oag_sequencer.sv
module oag_sequencer
  import oag_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [WORD_W-1:0] base_i,
  input  logic [WORD_W-1:0] imm_i,
  input  logic [WORD_W-1:0] ea_i,
  input  logic [WORD_W-1:0] wb_val_i,
  output logic              mem_rd_en_o,
  output logic [WORD_W-1:0] mem_addr_o,
  input  logic [WORD_W-1:0] mem_rdata_i,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic [WORD_W-1:0] res_data_o,
  output logic              res_illegal_o,
  output logic              wb_en_o,
  output logic [WORD_W-1:0] wb_data_o
);

  seq_e              state_q;
  logic [MODE_W-1:0] mode_q;
  logic [WORD_W-1:0] addr_q;
  logic [WORD_W-1:0] data_q;
  logic [WORD_W-1:0] wbv_q;
  logic              ill_q;
  logic              accept;
  logic              chase;

  assign accept = req_valid_i && (state_q == S_IDLE);
  assign chase  = (mode_q == AM_MIND);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      mode_q  <= '0;
      addr_q  <= '0;
      data_q  <= '0;
      wbv_q   <= '0;
      ill_q   <= 1'b0;
    end else begin
      unique case (state_q)
        S_IDLE: begin
          if (accept) begin
            mode_q <= mode_i;
            addr_q <= ea_i;
            wbv_q  <= wb_val_i;
            ill_q  <= !mode_legal(mode_i);
            if (!mode_legal(mode_i)) begin
              data_q  <= '0;
              state_q <= S_DONE;
            end else if (mode_no_mem(mode_i)) begin
              data_q  <= (mode_i == AM_REG) ? base_i : imm_i;
              state_q <= S_DONE;
            end else begin
              state_q <= S_RD1;
            end
          end
        end
        S_RD1:  state_q <= S_CAP1;
        S_CAP1: begin
          if (chase) begin
            state_q <= S_CAP2;
          end else begin
            data_q  <= mem_rdata_i;
            state_q <= S_DONE;
          end
        end
        S_CAP2: begin
          data_q  <= mem_rdata_i;
          state_q <= S_DONE;
        end
        S_DONE: begin
          if (res_ready_i) begin
            ill_q   <= 1'b0;
            state_q <= S_IDLE;
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  // first read from the latched address; a pointer chase reissues with returned data
  always_comb begin
    req_ready_o   = (state_q == S_IDLE);
    mem_rd_en_o   = (state_q == S_RD1) || ((state_q == S_CAP1) && chase);
    mem_addr_o    = (state_q == S_CAP1) ? mem_rdata_i : addr_q;
    res_valid_o   = (state_q == S_DONE);
    res_data_o    = data_q;
    res_illegal_o = (state_q == S_DONE) && ill_q;
    wb_en_o       = (state_q == S_DONE) && mode_has_wb(mode_q);
    wb_data_o     = wbv_q;
  end

  // R11: result held under back-pressure
  a_r11_result_hold: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_data_o)
      && $stable(res_illegal_o) && $stable(wb_en_o) && $stable(wb_data_o));

  // R1: no request taken while a read is in flight
  a_r1_busy_on_read: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |-> !req_ready_o);

  // R12: read data is consumed in the cycle after the strobe, never skipped
  a_r12_read_gap: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd_en_o |=> !res_valid_o);

  // R10: write-back only alongside a valid result
  a_r10_wb_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en_o |-> res_valid_o);

  // R9: illegal result never writes back
  a_r9_illegal_no_wb: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid_o && res_illegal_o |-> !wb_en_o);

endmodule

// File: rtl/operand_addr_gen.sv
module operand_addr_gen
  import oag_pkg::*;
#(
  parameter int unsigned WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [MODE_W-1:0] req_mode,
  input  logic [SIZE_W-1:0] req_size,
  input  logic [WORD_W-1:0] req_base,
  input  logic [WORD_W-1:0] req_index,
  input  logic [WORD_W-1:0] req_const,
  input  logic [WORD_W-1:0] req_imm,
  output logic              mem_rd_en,
  output logic [WORD_W-1:0] mem_addr,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [WORD_W-1:0] res_data,
  output logic              res_illegal,
  output logic              wb_en,
  output logic [WORD_W-1:0] wb_data
);

  logic [WORD_W-1:0] ea;
  logic [WORD_W-1:0] wb_val;

  oag_ea_unit #(.WORD_W(WORD_W)) ea_u (
    .mode_i   (req_mode),
    .size_i   (req_size),
    .base_i   (req_base),
    .index_i  (req_index),
    .konst_i  (req_const),
    .ea_o     (ea),
    .wb_val_o (wb_val)
  );

  oag_sequencer #(.WORD_W(WORD_W)) seq_u (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid_i   (req_valid),
    .req_ready_o   (req_ready),
    .mode_i        (req_mode),
    .base_i        (req_base),
    .imm_i         (req_imm),
    .ea_i          (ea),
    .wb_val_i      (wb_val),
    .mem_rd_en_o   (mem_rd_en),
    .mem_addr_o    (mem_addr),
    .mem_rdata_i   (mem_rdata),
    .res_valid_o   (res_valid),
    .res_ready_i   (res_ready),
    .res_data_o    (res_data),
    .res_illegal_o (res_illegal),
    .wb_en_o       (wb_en),
    .wb_data_o     (wb_data)
  );

endmodule

// File: tb/operand_addr_gen_tb_top.sv
`timescale 1ns/1ps
module operand_addr_gen_tb_top;

  localparam int unsigned W = 16;

  typedef struct {
    logic [W-1:0] data;
    bit           ill;
    bit           wbe;
    logic [W-1:0] wbv;
    int           acc;
    int           lat;
    string        rq;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n;
  logic         req_valid;
  logic         req_ready;
  logic [3:0]   req_mode;
  logic [1:0]   req_size;
  logic [W-1:0] req_base, req_index, req_const, req_imm;
  logic         mem_rd_en;
  logic [W-1:0] mem_addr;
  logic [W-1:0] mem_rdata;
  logic         res_valid;
  logic         res_ready;
  logic [W-1:0] res_data;
  logic         res_illegal;
  logic         wb_en;
  logic [W-1:0] wb_data;

  int   cyc = 0;
  int   total = 0;
  int   fails = 0;
  bit   stall_mode = 1'b0;
  bit   lat_seen = 1'b0;
  exp_t exp_q[$];
  logic [W-1:0] addr_q[$];

  always #4 clk = ~clk;

  operand_addr_gen #(.WORD_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_mode(req_mode), .req_size(req_size),
    .req_base(req_base), .req_index(req_index),
    .req_const(req_const), .req_imm(req_imm),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .res_valid(res_valid), .res_ready(res_ready),
    .res_data(res_data), .res_illegal(res_illegal),
    .wb_en(wb_en), .wb_data(wb_data)
  );

  function automatic logic [W-1:0] memf(input logic [W-1:0] a);
    logic [W-1:0] p;
    p = a * 16'h03B1;
    return p ^ 16'h5A3C;
  endfunction

  // memory model: one-cycle read latency
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mem_rd_en) mem_rdata <= memf(mem_addr);
  end

  task automatic chk(input bit ok, input string rq, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
    end
  endtask

  task automatic send(input logic [3:0] m, input logic [W-1:0] b, input logic [W-1:0] x,
                      input logic [W-1:0] k, input logic [W-1:0] im, input logic [1:0] sz,
                      input string rq);
    exp_t e;
    logic [W-1:0] step, a1, a2;
    int nrd;
    step = W'(1) << sz;
    e.ill = 0; e.wbe = 0; e.wbv = '0; e.rq = rq; nrd = 1; a1 = '0; a2 = '0;
    case (m)
      4'd0: begin e.data = b;  nrd = 0; end
      4'd1: begin e.data = im; nrd = 0; end
      4'd2: a1 = k + b;
      4'd3: a1 = b;
      4'd4: a1 = b + x;
      4'd5: a1 = k;
      4'd6: begin a1 = b; a2 = memf(b); nrd = 2; end
      4'd7: begin a1 = b; e.wbe = 1; e.wbv = b + step; end
      4'd8: begin a1 = b - step; e.wbe = 1; e.wbv = b - step; end
      4'd9: a1 = k + b + (x << sz);
      default: begin e.data = '0; e.ill = 1; nrd = 0; end
    endcase
    if (nrd == 1) e.data = memf(a1);
    if (nrd == 2) e.data = memf(a2);
    e.lat = (nrd == 0) ? 1 : (nrd == 1 ? 3 : 4);
    @(negedge clk);
    req_mode = m; req_size = sz; req_base = b; req_index = x;
    req_const = k; req_imm = im; req_valid = 1'b1;
    while (!req_ready) @(negedge clk);
    e.acc = cyc;
    exp_q.push_back(e);
    if (nrd >= 1) addr_q.push_back(a1);
    if (nrd == 2) addr_q.push_back(a2);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    exp_t e;
    logic [W-1:0] a;
    res_ready = !stall_mode || (cyc % 3 == 0);
    if (rst_n) begin
      if (mem_rd_en) begin
        if (addr_q.size() == 0) chk(1'b0, "R12", "unexpected read", 32'(mem_addr), 0);
        else begin
          a = addr_q.pop_front();
          chk(mem_addr == a, "R12", "read address", 32'(mem_addr), 32'(a));
        end
      end
      if (res_valid) begin
        if (exp_q.size() == 0) chk(1'b0, "R11", "result without request", 32'(res_data), 0);
        else begin
          e = exp_q[0];
          if (!lat_seen) begin
            chk(cyc - e.acc == e.lat, e.rq, "latency", 32'(cyc - e.acc), 32'(e.lat));
            chk(!req_ready, "R1", "ready low while result pending", 32'(req_ready), 0);
            lat_seen = 1'b1;
          end
          chk(res_data == e.data, e.rq, "operand", 32'(res_data), 32'(e.data));
          chk(res_illegal == e.ill, "R9", "illegal flag", 32'(res_illegal), 32'(e.ill));
          chk(wb_en == e.wbe, "R10", "wb enable", 32'(wb_en), 32'(e.wbe));
          if (e.wbe) chk(wb_data == e.wbv, e.rq, "wb value", 32'(wb_data), 32'(e.wbv));
          if (res_ready) begin
            void'(exp_q.pop_front());
            lat_seen = 1'b0;
          end
        end
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    chk(1'b0, "R1", "watchdog expired", 0, 0);
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; req_mode = '0; req_size = '0;
    req_base = '0; req_index = '0; req_const = '0; req_imm = '0;
    repeat (3) @(negedge clk);
    chk(req_ready == 1'b1, "R1", "reset ready", 32'(req_ready), 1);
    chk(res_valid == 1'b0, "R1", "reset res_valid", 32'(res_valid), 0);
    chk(mem_rd_en == 1'b0, "R1", "reset mem_rd_en", 32'(mem_rd_en), 0);
    rst_n = 1'b1;
    send(4'd0, 16'h1234, 16'h0, 16'h0, 16'h0, 2'd0, "R2");
    send(4'd1, 16'h1234, 16'h0, 16'h0, 16'hBEEF, 2'd0, "R2");
    send(4'd2, 16'h0100, 16'h0, 16'h0020, 16'h0, 2'd2, "R3");
    send(4'd3, 16'h0456, 16'h0, 16'h0, 16'h0, 2'd0, "R3");
    send(4'd4, 16'h1000, 16'h0234, 16'h0, 16'h0, 2'd1, "R3");
    send(4'd5, 16'h1111, 16'h2222, 16'h7777, 16'h0, 2'd3, "R3");
    send(4'd6, 16'h0200, 16'h0, 16'h0, 16'h0, 2'd0, "R4");
    send(4'd6, 16'hFFF0, 16'h0, 16'h0, 16'h0, 2'd0, "R4");
    for (int s = 0; s < 4; s++) send(4'd7, 16'h0300, 16'h0, 16'h0, 16'h0, 2'(s), "R8");
    send(4'd7, 16'hFFFF, 16'h0, 16'h0, 16'h0, 2'd3, "R5");
    send(4'd8, 16'h0400, 16'h0, 16'h0, 16'h0, 2'd2, "R6");
    send(4'd8, 16'h0000, 16'h0, 16'h0, 16'h0, 2'd0, "R6");
    for (int s = 0; s < 4; s++) send(4'd9, 16'h0100, 16'h0003, 16'h0010, 16'h0, 2'(s), "R7");
    send(4'd9, 16'hFFF0, 16'h4001, 16'h0020, 16'h0, 2'd2, "R7");
    send(4'd10, 16'h0500, 16'h0, 16'h0, 16'h0, 2'd0, "R9");
    send(4'd15, 16'h0500, 16'h0, 16'h0, 16'h0, 2'd3, "R9");
    stall_mode = 1'b1;
    send(4'd6, 16'h0321, 16'h0, 16'h0, 16'h0, 2'd0, "R11");
    send(4'd7, 16'h0700, 16'h0, 16'h0, 16'h0, 2'd1, "R11");
    send(4'd0, 16'hA5A5, 16'h0, 16'h0, 16'h0, 2'd0, "R11");
    send(4'd12, 16'h0, 16'h0, 16'h0, 16'h0, 2'd0, "R11");
    while (exp_q.size() != 0) @(negedge clk);
    stall_mode = 1'b0;
    repeat (3) @(negedge clk);
    chk(addr_q.size() == 0, "R2", "missing reads", 32'(addr_q.size()), 0);
    chk(req_ready == 1'b1, "R1", "ready after drain", 32'(req_ready), 1);
    finish_run();
  end

endmodule